// File: doc/BRIEF.md
# Two-Level Hierarchical Interrupt Controller

This block gathers single-cycle event pulses from the seven functional units of an ATM-over-DS3 line interface. It drives a single active-low interrupt request to a host processor. Every event latches into a sticky source status bit. Each unit then folds its enabled source bits into one summary bit, and the request is asserted when an enabled summary bit is set.

The host services an interrupt in two reads. The first read returns the unit summaries and shows which unit is calling. The second read returns that unit's source status, which names the exact event and also clears the bits it returned. Enables at both levels are written and read back over a simple synchronous register bus.

Top module: `irq_hier_ctrl`

## Requirements
- R1: After reset the request output is high, and every status and enable register reads as zero.
- R2: A one-cycle pulse on an event input sets its source status bit at the next clock edge, whatever the state of that source's enable. Event inputs are indexed in unit order, and each unit's sources occupy consecutive bits starting at bit 0 of that unit's status register. The units are, in order: transmit cell interface (3 sources), transmit cell processor (1), transmit convergence sublayer (0), transmit framer (2), receive framer (4), receive convergence sublayer (2) and receive cell processor (3).
- R3: A set source status bit stays set, whatever other events arrive, until its unit's source status register is read.
- R4: Reading a unit's source status register returns its bits and clears them. An event that arrives in the same cycle as that read is not returned, and it stays set for the next read.
- R5: The unit summary register is at address 0, with bit b for unit b. Bit b is the OR over unit b's source status bits, each ANDed with its source enable. Reading this register changes no state.
- R6: The request output is low exactly when some unit summary bit is set while its unit enable bit is set.
- R7: The unit enable register (address 1, bit b for unit b) and the source enable registers (address 9+b for unit b) keep only the bits that have a unit or a source behind them. All other bits read as zero.
- R8: Source status for unit b is at address 2+b. A read strobe returns data on the read-data port after the next clock edge. Addresses 16 to 31 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 15 | Event pulses, one bit per source |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
Two functions can land on the same clock edge: a destructive read of a unit's source status, and a new event pulse on one of that unit's sources. The bench drives the read strobe and the event pulse in the same cycle for every source. It does this once with the same bit already pending and once with a different bit of that unit pending. The returned word must hold only the bits that were pending before that edge, and a second read must return exactly the bit that arrived during the first read.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NUM_BLK = 7;
    localparam int MAX_SRC = 4;
    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 8;

    localparam int A_BLK_STAT  = 0;
    localparam int A_BLK_EN    = 1;
    localparam int A_SRC_STAT0 = 2;
    localparam int A_SRC_EN0   = A_SRC_STAT0 + NUM_BLK;

    function automatic int src_cnt(input int b);
        case (b)
            0:       return 3;
            1:       return 1;
            2:       return 0;
            3:       return 2;
            4:       return 4;
            5:       return 2;
            6:       return 3;
            default: return 0;
        endcase
    endfunction

    function automatic int src_base(input int b);
        int acc;
        acc = 0;
        for (int k = 0; k < b; k++) acc += src_cnt(k);
        return acc;
    endfunction

    localparam int TOTAL_SRC = src_base(NUM_BLK);

    function automatic int src_blk(input int s);
        int r;
        r = 0;
        for (int k = 0; k < NUM_BLK; k++)
            if (s >= src_base(k) && s < src_base(k) + src_cnt(k)) r = k;
        return r;
    endfunction

    typedef struct packed {
        logic [MAX_SRC-1:0] stat;
        logic [MAX_SRC-1:0] en;
    } bank_t;

    typedef struct packed {
        logic [NUM_BLK-1:0] blk_en;
        logic [DATA_W-1:0]  rdata;
    } top_t;

endpackage

// File: rtl/irqc_src_bank.sv
module irqc_src_bank
    import irqc_pkg::*;
#(
    parameter int NSRC = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MAX_SRC-1:0] evt_i,
    input  logic               rd_clr_i,
    input  logic               wr_en_i,
    input  logic [MAX_SRC-1:0] wdata_i,
    output logic [MAX_SRC-1:0] stat_o,
    output logic [MAX_SRC-1:0] en_o,
    output logic               summary_o
);

    localparam logic [MAX_SRC-1:0] IMPL = MAX_SRC'((32'd1 << NSRC) - 32'd1);

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (rd_clr_i) bank_d.stat = '0;
        bank_d.stat = (bank_d.stat | evt_i) & IMPL;
        if (wr_en_i) bank_d.en = wdata_i & IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign stat_o    = bank_q.stat;
    assign en_o      = bank_q.en;
    assign summary_o = |(bank_q.stat & bank_q.en);

endmodule

// File: rtl/irqc_readmux.sv
module irqc_readmux
    import irqc_pkg::*;
(
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [NUM_BLK-1:0]         blk_sum_i,
    input  logic [NUM_BLK-1:0]         blk_en_i,
    input  logic [NUM_BLK*MAX_SRC-1:0] stat_i,
    input  logic [NUM_BLK*MAX_SRC-1:0] en_i,
    output logic [DATA_W-1:0]          data_o
);

    always_comb begin
        data_o = '0;
        if (addr_i == ADDR_W'(A_BLK_STAT)) data_o = DATA_W'(blk_sum_i);
        if (addr_i == ADDR_W'(A_BLK_EN))   data_o = DATA_W'(blk_en_i);
        for (int b = 0; b < NUM_BLK; b++) begin
            if (addr_i == ADDR_W'(A_SRC_STAT0 + b))
                data_o = DATA_W'(stat_i[b*MAX_SRC +: MAX_SRC]);
            if (addr_i == ADDR_W'(A_SRC_EN0 + b))
                data_o = DATA_W'(en_i[b*MAX_SRC +: MAX_SRC]);
        end
    end

endmodule

// File: rtl/irq_hier_ctrl.sv
module irq_hier_ctrl
    import irqc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TOTAL_SRC-1:0] evt_i,
    input  logic                 rd_en_i,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [DATA_W-1:0]    rdata_o,
    output logic                 irq_n_o
);

    logic [NUM_BLK-1:0]         blk_sum;
    logic [NUM_BLK*MAX_SRC-1:0] stat_all;
    logic [NUM_BLK*MAX_SRC-1:0] en_all;
    logic [TOTAL_SRC-1:0]       src_stat_flat;
    logic [TOTAL_SRC-1:0]       src_en_flat;
    logic [DATA_W-1:0]          mux_data;
    logic [NUM_BLK-1:0]         blk_en_q;
    top_t                       top_d, top_q;

    for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
        localparam int CNT  = src_cnt(b);
        localparam int BASE = src_base(b);
        logic [MAX_SRC-1:0] evt_b;
        logic               clr_b;
        logic               wen_b;

        for (genvar i = 0; i < MAX_SRC; i++) begin : g_bit
            if (i < CNT) begin : g_on
                assign evt_b[i]              = evt_i[BASE+i];
                assign src_stat_flat[BASE+i] = stat_all[b*MAX_SRC+i];
                assign src_en_flat[BASE+i]   = en_all[b*MAX_SRC+i];
            end else begin : g_off
                assign evt_b[i] = 1'b0;
            end
        end

        assign clr_b = rd_en_i && (addr_i == ADDR_W'(A_SRC_STAT0 + b));
        assign wen_b = wr_en_i && (addr_i == ADDR_W'(A_SRC_EN0 + b));

        irqc_src_bank #(.NSRC(CNT)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt_i    (evt_b),
            .rd_clr_i (clr_b),
            .wr_en_i  (wen_b),
            .wdata_i  (wdata_i[MAX_SRC-1:0]),
            .stat_o   (stat_all[b*MAX_SRC +: MAX_SRC]),
            .en_o     (en_all[b*MAX_SRC +: MAX_SRC]),
            .summary_o(blk_sum[b])
        );
    end

    irqc_readmux u_mux (
        .addr_i   (addr_i),
        .blk_sum_i(blk_sum),
        .blk_en_i (top_q.blk_en),
        .stat_i   (stat_all),
        .en_i     (en_all),
        .data_o   (mux_data)
    );

    always_comb begin
        top_d = top_q;
        if (rd_en_i) top_d.rdata = mux_data;
        if (wr_en_i && addr_i == ADDR_W'(A_BLK_EN))
            top_d.blk_en = wdata_i[NUM_BLK-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign blk_en_q = top_q.blk_en;
    assign rdata_o  = top_q.rdata;
    assign irq_n_o  = ~|(blk_sum & top_q.blk_en);

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [TOTAL_SRC-1:0] evt_i,
    input logic                 rd_en_i,
    input logic [ADDR_W-1:0]    addr_i,
    input logic                 irq_n_o,
    input logic [TOTAL_SRC-1:0] src_stat,
    input logic [TOTAL_SRC-1:0] src_en,
    input logic [NUM_BLK-1:0]   blk_en
);

    logic [TOTAL_SRC-1:0] clr_mask;

    always_comb begin
        for (int s = 0; s < TOTAL_SRC; s++)
            clr_mask[s] = rd_en_i && (addr_i == ADDR_W'(A_SRC_STAT0 + src_blk(s)));
    end

    AST_EVT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((src_stat & $past(evt_i)) == $past(evt_i)));                  // R2

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (|(src_stat & ~clr_mask)) |=>
            ((src_stat & $past(src_stat & ~clr_mask)) == $past(src_stat & ~clr_mask))); // R3

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_mask) |=> ((src_stat & $past(clr_mask & ~evt_i)) == '0));             // R4

    AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n_o |-> ((|(src_stat & src_en)) && (|blk_en)));                         // R6

    AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_en == '0) |-> irq_n_o);                                                 // R6

endmodule

bind irq_hier_ctrl irqc_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .irq_n_o (irq_n_o),
    .src_stat(src_stat_flat),
    .src_en  (src_en_flat),
    .blk_en  (blk_en_q)
);

// File: tb/irq_hier_ctrl_tb.sv
`timescale 1ns/1ps
module irq_hier_ctrl_tb;

    localparam int NB = 7;
    localparam int NS = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] evt = '0;
    logic          rd_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [4:0]    addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          irq_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [NS-1:0] m_src = '0;
    logic [NS-1:0] m_sen = '0;
    logic [NB-1:0] m_ben = '0;

    always #10 clk = ~clk;

    irq_hier_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .rd_en_i(rd_en), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_n_o(irq_n)
    );

    function automatic int cnt(input int b);
        int t[NB] = '{3, 1, 0, 2, 4, 2, 3};
        return t[b];
    endfunction

    function automatic int base(input int b);
        int a = 0;
        for (int k = 0; k < b; k++) a += cnt(k);
        return a;
    endfunction

    function automatic int blk_of(input int s);
        int r = 0;
        for (int k = 0; k < NB; k++) if (s >= base(k) && s < base(k) + cnt(k)) r = k;
        return r;
    endfunction

    function automatic logic [7:0] pack(input logic [NS-1:0] v, input int b);
        logic [7:0] r = '0;
        for (int i = 0; i < cnt(b); i++) r[i] = v[base(b) + i];
        return r;
    endfunction

    function automatic logic [NB-1:0] exp_sum();
        logic [NB-1:0] r = '0;
        for (int b = 0; b < NB; b++) r[b] = |pack(m_src & m_sen, b);
        return r;
    endfunction

    function automatic logic [7:0] exp_rd(input int a);
        if (a == 0) return {1'b0, exp_sum()};
        if (a == 1) return {1'b0, m_ben};
        if (a >= 2 && a < 2 + NB) return pack(m_src, a - 2);
        if (a >= 2 + NB && a < 2 + 2 * NB) return pack(m_sen, a - 2 - NB);
        return 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_irq(input string tag);
        chk(tag, {7'd0, irq_n}, {7'd0, ~|(exp_sum() & m_ben)});
    endtask

    task automatic do_rd(input int a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = 5'(a);
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
        if (a >= 2 && a < 2 + NB)
            for (int i = 0; i < cnt(a - 2); i++) m_src[base(a - 2) + i] = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int a);
        logic [7:0] e, d;
        e = exp_rd(a);
        do_rd(a, d);
        chk(tag, d, e);
    endtask

    task automatic do_wr(input int a, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = 5'(a); wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 1) m_ben = v[NB-1:0];
        if (a >= 2 + NB && a < 2 + 2 * NB)
            for (int i = 0; i < cnt(a - 2 - NB); i++) m_sen[base(a - 2 - NB) + i] = v[i];
    endtask

    task automatic pulse(input logic [NS-1:0] v);
        @(negedge clk);
        evt = v;
        @(negedge clk);
        evt = '0;
        m_src = m_src | v;
    endtask

    task automatic clash(input int s_old, input int s_new);
        int b;
        logic [7:0] e;
        b = blk_of(s_new);
        pulse(NS'(1) << s_old);
        e = pack(m_src, b);
        @(negedge clk);
        rd_en = 1'b1; addr = 5'(2 + b); evt = NS'(1) << s_new;
        @(negedge clk);
        rd_en = 1'b0; evt = '0;
        chk("R4 read with coincident event", rdata, e);
        for (int i = 0; i < cnt(b); i++) m_src[base(b) + i] = 1'b0;
        m_src[s_new] = 1'b1;
        rd_chk("R4 coincident event kept", 2 + b);
        rd_chk("R4 cleared after second read", 2 + b);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 irq idle after reset", {7'd0, irq_n}, 8'h01);
        for (int a = 0; a < 32; a++) rd_chk((a < 16) ? "R1 reset read" : "R8 unmapped read", a);

        do_wr(1, 8'hFF);
        for (int b = 0; b < NB; b++) do_wr(2 + NB + b, 8'hFF);
        rd_chk("R7 block enable mask", 1);
        for (int b = 0; b < NB; b++) rd_chk("R7 source enable mask", 2 + NB + b);
        for (int a = 16; a < 32; a += 5) begin
            do_wr(a, 8'hFF);
            rd_chk("R8 unmapped write ignored", a);
        end
        do_wr(1, 8'h00);
        for (int b = 0; b < NB; b++) do_wr(2 + NB + b, 8'h00);

        for (int s = 0; s < NS; s++) begin
            int b;
            b = blk_of(s);
            pulse(NS'(1) << s);
            rd_chk("R5 summary ignores disabled source", 0);
            chk_irq("R6 irq high without enables");
            do_wr(2 + NB + b, 8'(1 << (s - base(b))));
            rd_chk("R5 summary with source enabled", 0);
            chk_irq("R6 irq high with unit disabled");
            do_wr(1, 8'(1 << b));
            chk_irq("R6 irq low when unit enabled");
            do_wr(1, 8'(~(1 << b)) & 8'h7F);
            chk_irq("R6 irq high with only other units enabled");
            repeat (5) @(negedge clk);
            rd_chk("R3 summary still set after idle", 0);
            do_wr(1, 8'(1 << b));
            rd_chk("R2 source status bit position", 2 + b);
            chk_irq("R6 irq released after read clear");
            rd_chk("R4 status clear after read", 2 + b);
            do_wr(2 + NB + b, 8'h00);
            do_wr(1, 8'h00);
        end

        pulse('1);
        pulse(15'h0001);
        for (int b = 0; b < NB; b++) rd_chk("R2 status set without enables", 2 + b);

        for (int b = 0; b < NB; b++) do_wr(2 + NB + b, 8'h0F);
        do_wr(1, 8'h7F);
        pulse('1);
        rd_chk("R5 all units summary", 0);
        chk("R5 summary value", {1'b0, exp_sum()}, 8'h7B);
        chk_irq("R6 irq with all enabled");
        for (int b = 0; b < NB; b++) rd_chk("R4 drain unit", 2 + b);
        chk_irq("R6 irq released after drain");

        for (int s = 0; s < NS; s++) begin
            int b, o;
            b = blk_of(s);
            clash(s, s);
            o = (cnt(b) > 1) ? base(b) + ((s - base(b) + 1) % cnt(b)) : s;
            clash(o, s);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule